// File: doc/BRIEF.md
# ADC Conversion Sequencer Controller

This block walks a programmable table of conversion entries and feeds the results into a sample FIFO. Each entry names an input channel and a settle delay in clock cycles. For each entry the block waits that delay, then requests a conversion from a behavioural converter stand-in. The stand-in answers after a fixed latency with a value derived from the channel. The result goes into a 32-deep FIFO. Software programs the block through a simple write/read register port. It loads the table two entries per 32-bit word, sets the entry count and a FIFO threshold, and then starts the sequence.

In single-shot mode the sequencer halts after the last entry and stays there until a resume command restarts it from entry 0. In repetitive mode it wraps to entry 0 and runs until a resume command stops it. Software drains the FIFO by writing a pop command and then reading the sample register. A receive interrupt flags that the threshold was reached. An error interrupt flags a dropped sample or a pop from an empty FIFO. Each interrupt is cleared by its own command.

Register map: 0 control, 1 settings, 2 table load, 3 sample (read), 4 status (read). Unlisted reads return 0.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset both interrupts are low and the status register (address 4) reads 0.
- R2: A write to address 2 stores two entries: the even entry takes its channel from bits 4:0 and its delay from bits 15:5, and the odd entry takes its channel from bits 20:16 and its delay from bits 31:21. The table write pointer then advances by two. Control bit 2 (pointer reset) returns both the write pointer and the conversion pointer to entry 0.
- R3: Control bit 3 (start) is taken only while the block is enabled. It begins at entry 0. Each entry's sample enters the FIFO d+1+4 cycles after the start edge or after the previous entry's sample, where d is the entry's delay. The sample value is {4'hA, 2'b00, ~ch, ch} for channel ch. Status bits 7:0 give the FIFO level.
- R4: With settings bit 13 clear (single-shot), the sequencer stops after entry N, where N is settings bits 21:16, and sets status bit 12 (halted). Control bit 4 (resume) restarts it from entry 0.
- R5: With settings bit 13 set (repetitive), entry 0 follows the last entry with no pause. Resume stops the sequence and clears status bit 11 (busy).
- R6: A settings write with bit 14 set (pop) moves the oldest sample into the sample register (address 3) and removes it from the FIFO. The other settings fields are written from the same word.
- R7: A pop on an empty FIFO loads 0 into the sample register and sets the underflow flag (status bit 10).
- R8: A sample that completes while 32 samples are held and no pop occurs is dropped. The overflow flag (status bit 9) is set, and the level never exceeds 32.
- R9: The receive flag (status bit 8) is set when an accepted sample brings the level above settings bits 29:24. Control bit 5 clears it; a set in the same cycle takes priority.
- R10: A settings write with bit 15 set (flush) empties the FIFO. A sample completing in that cycle is discarded.
- R11: Control bit 6 clears the overflow and underflow flags, and with them the error interrupt.
- R12: The receive interrupt is the receive flag, and the error interrupt is the OR of the two error flags. Both are gated by control bit 0 (enable) set and control bit 1 (interrupt disable) clear. While enable is clear the sequencer idles and start is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for writes and reads |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for addr |
| irq_rx | output | 1 | Receive (threshold) interrupt |
| irq_err | output | 1 | Error (overflow/underflow) interrupt |

## Verification
Register writes, pops and flushes take effect at the clock edge that captures the write. Flags and interrupts therefore change in the cycle after that edge. A sample lands d+1+4 edges after the start edge or after the previous sample. The bench keeps its own model of the FIFO contents, the flags and the countdown to each sample. It advances the model on every rising edge and compares the interrupts and the status word one nanosecond later, once the design's registers have settled. Sample values are read back one edge after each pop command and compared with values computed from the channel formula.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CH_W  = 5;
  localparam int DLY_W = 11;
  localparam int SMP_W = 16;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_SET  = 3'd1;
  localparam logic [2:0] A_TBL  = 3'd2;
  localparam logic [2:0] A_SMP  = 3'd3;
  localparam logic [2:0] A_STAT = 3'd4;

  localparam int C_EN = 0, C_IDIS = 1, C_PRST = 2, C_GO = 3, C_RESUME = 4, C_CLRD = 5, C_CLRE = 6;
  localparam int S_MODE = 13, S_POP = 14, S_FLUSH = 15, S_CNT = 16, S_THR = 24;

  typedef enum logic [1:0] {SQ_IDLE, SQ_DELAY, SQ_WAIT, SQ_HOLD} sq_state_e;

  typedef struct packed {
    logic [DLY_W-1:0] dly;
    logic [CH_W-1:0]  ch;
  } seq_ent_t;

  function automatic logic [SMP_W-1:0] conv_value(input logic [CH_W-1:0] ch);
    return {4'hA, 2'b00, ~ch, ch};
  endfunction

  function automatic logic over_thr(input int unsigned lvl, input int unsigned thr_m1);
    return lvl > thr_m1;
  endfunction
endpackage

// File: rtl/adc_sample_src.sv
module adc_sample_src import adc_seq_pkg::*; #(
  parameter int LAT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             req,
  input  logic [CH_W-1:0]  ch,
  output logic             done,
  output logic [SMP_W-1:0] data
);
  logic [LAT-1:0] vld_q;
  logic [CH_W-1:0] ch_q [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (clear) begin
      vld_q <= '0;
    end else begin
      vld_q[0] <= req;
      for (int i = 1; i < LAT; i++) vld_q[i] <= vld_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    ch_q[0] <= ch;
    for (int i = 1; i < LAT; i++) ch_q[i] <= ch_q[i-1];
  end

  assign done = vld_q[LAT-1];
  assign data = conv_value(ch_q[LAT-1]);
endmodule

// File: rtl/adc_sample_fifo.sv
module adc_sample_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic                         pop,
  input  logic                         flush,
  input  logic [W-1:0]                 din,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         full,
  output logic                         push_acc,
  output logic                         push_drop,
  output logic                         pop_hit,
  output logic                         pop_miss
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rp_q, wp_q;
  logic [LW-1:0] cnt_q;
  logic          empty;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == LW'(DEPTH));
  assign pop_hit   = pop && !empty;
  assign pop_miss  = pop && empty;
  assign push_acc  = push && (!full || pop_hit);
  assign push_drop = push && full && !pop_hit;
  assign dout      = mem[rp_q];
  assign level     = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp_q  <= '0;
      wp_q  <= '0;
      cnt_q <= '0;
    end else if (flush) begin
      rp_q  <= '0;
      wp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (pop_hit)  rp_q <= bump(rp_q);
      if (push_acc) wp_q <= bump(wp_q);
      cnt_q <= cnt_q + LW'(push_acc) - LW'(pop_hit);
    end
  end

  always_ff @(posedge clk) begin
    if (push_acc && !flush) mem[wp_q] <= din;
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl import adc_seq_pkg::*; #(
  parameter int MAX_ENTRIES = 64,
  parameter int FIFO_DEPTH  = 32,
  parameter int CONV_LAT    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq_rx,
  output logic        irq_err
);
  localparam int IDX_W = $clog2(MAX_ENTRIES);
  localparam int LVL_W = $clog2(FIFO_DEPTH+1);

  // register decode
  logic ctrl_wr, set_wr, tbl_wr;
  logic go_cmd, resume_cmd, prst_cmd, clrd_cmd, clre_cmd, pop_cmd, flush_cmd;
  assign ctrl_wr    = wr_en && (addr == A_CTRL);
  assign set_wr     = wr_en && (addr == A_SET);
  assign tbl_wr     = wr_en && (addr == A_TBL);
  logic en_q, idis_q;
  assign go_cmd     = ctrl_wr && wdata[C_GO] && en_q;
  assign resume_cmd = ctrl_wr && wdata[C_RESUME];
  assign prst_cmd   = ctrl_wr && wdata[C_PRST];
  assign clrd_cmd   = ctrl_wr && wdata[C_CLRD];
  assign clre_cmd   = ctrl_wr && wdata[C_CLRE];
  assign pop_cmd    = set_wr && wdata[S_POP];
  assign flush_cmd  = set_wr && wdata[S_FLUSH];

  logic [13:0] set_lo_q;
  logic [5:0]  cnt_m1_q, thr_m1_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; idis_q <= 1'b0;
      set_lo_q <= '0; cnt_m1_q <= '0; thr_m1_q <= '0;
    end else begin
      if (ctrl_wr) begin
        en_q   <= wdata[C_EN];
        idis_q <= wdata[C_IDIS];
      end
      if (set_wr) begin
        set_lo_q <= wdata[13:0];
        cnt_m1_q <= wdata[S_CNT +: 6];
        thr_m1_q <= wdata[S_THR +: 6];
      end
    end
  end

  // entry table, two entries per write
  seq_ent_t         tbl [MAX_ENTRIES];
  logic [IDX_W-1:0] wptr_q;
  always_ff @(posedge clk) begin
    if (tbl_wr) begin
      tbl[wptr_q]               <= seq_ent_t'(wdata[15:0]);
      tbl[wptr_q + IDX_W'(1)]   <= seq_ent_t'(wdata[31:16]);
    end
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wptr_q <= '0;
    else if (prst_cmd) wptr_q <= '0;
    else if (tbl_wr)   wptr_q <= wptr_q + IDX_W'(2);
  end

  // sequencer
  sq_state_e        st_q;
  logic [IDX_W-1:0] idx_q, idx_nx;
  logic [DLY_W-1:0] dcnt_q;
  logic             last_ent, conv_req, seq_kill, src_done, push_evt;
  logic             seq_busy, seq_hold;
  logic [SMP_W-1:0] src_data;

  assign idx_nx   = idx_q + IDX_W'(1);
  assign last_ent = (idx_q == IDX_W'(cnt_m1_q));
  assign conv_req = (st_q == SQ_DELAY) && (dcnt_q == '0);
  assign seq_kill = !en_q || go_cmd || resume_cmd;
  assign push_evt = (st_q == SQ_WAIT) && src_done && !seq_kill;
  assign seq_busy = (st_q == SQ_DELAY) || (st_q == SQ_WAIT);
  assign seq_hold = (st_q == SQ_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SQ_IDLE; idx_q <= '0; dcnt_q <= '0;
    end else begin
      if (!en_q) begin
        st_q <= SQ_IDLE;
      end else if (go_cmd || (resume_cmd && seq_hold)) begin
        st_q <= SQ_DELAY; idx_q <= '0; dcnt_q <= tbl[0].dly;
      end else if (resume_cmd) begin
        st_q <= SQ_IDLE;
      end else begin
        case (st_q)
          SQ_DELAY: begin
            if (dcnt_q == '0) st_q <= SQ_WAIT;
            else              dcnt_q <= dcnt_q - 1'b1;
          end
          SQ_WAIT: begin
            if (src_done) begin
              if (!last_ent) begin
                idx_q <= idx_nx; dcnt_q <= tbl[idx_nx].dly; st_q <= SQ_DELAY;
              end else if (set_lo_q[S_MODE]) begin
                idx_q <= '0; dcnt_q <= tbl[0].dly; st_q <= SQ_DELAY;
              end else begin
                st_q <= SQ_HOLD;
              end
            end
          end
          default: ;
        endcase
      end
      if (prst_cmd) idx_q <= '0;
    end
  end

  adc_sample_src #(.LAT(CONV_LAT)) u_src (
    .clk(clk), .rst_n(rst_n), .clear(seq_kill), .req(conv_req),
    .ch(tbl[idx_q].ch), .done(src_done), .data(src_data)
  );

  // sample FIFO
  logic [SMP_W-1:0] fifo_dout, sample_q;
  logic [LVL_W-1:0] fifo_level;
  logic fifo_full, push_acc, push_drop, pop_hit, pop_miss;

  adc_sample_fifo #(.DEPTH(FIFO_DEPTH), .W(SMP_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push_evt && !flush_cmd), .pop(pop_cmd),
    .flush(flush_cmd), .din(src_data), .dout(fifo_dout), .level(fifo_level),
    .full(fifo_full), .push_acc(push_acc), .push_drop(push_drop),
    .pop_hit(pop_hit), .pop_miss(pop_miss)
  );

  // flags
  logic rx_q, ovf_q, udf_q, rx_set;
  assign rx_set = push_acc &&
                  over_thr(int'(fifo_level) + int'(push_acc) - int'(pop_hit), int'(thr_m1_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= 1'b0; ovf_q <= 1'b0; udf_q <= 1'b0; sample_q <= '0;
    end else begin
      if (rx_set)         rx_q  <= 1'b1;
      else if (clrd_cmd)  rx_q  <= 1'b0;
      if (push_drop)      ovf_q <= 1'b1;
      else if (clre_cmd)  ovf_q <= 1'b0;
      if (pop_miss)       udf_q <= 1'b1;
      else if (clre_cmd)  udf_q <= 1'b0;
      if (pop_cmd)        sample_q <= pop_hit ? fifo_dout : '0;
    end
  end

  assign irq_rx  = rx_q && en_q && !idis_q;
  assign irq_err = (ovf_q || udf_q) && en_q && !idis_q;

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {30'b0, idis_q, en_q};
      A_SET:   rdata = {2'b0, thr_m1_q, 2'b0, cnt_m1_q, 2'b0, set_lo_q};
      A_SMP:   rdata = {{(32-SMP_W){1'b0}}, sample_q};
      A_STAT:  rdata = {19'b0, seq_hold, seq_busy, udf_q, ovf_q, rx_q, 8'(fifo_level)};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int FIFO_DEPTH = 32,
  parameter int LVL_W      = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_q,
  input logic             idis_q,
  input logic             irq_rx,
  input logic             irq_err,
  input logic             rx_q,
  input logic             ovf_q,
  input logic             udf_q,
  input logic             push_acc,
  input logic             push_drop,
  input logic             pop_miss,
  input logic             flush_cmd,
  input logic [LVL_W-1:0] fifo_level,
  input logic             conv_req,
  input logic             seq_hold,
  input logic [15:0]      sample_q
);
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fifo_level) <= FIFO_DEPTH);

  p_drop_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> ovf_q);

  p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop_miss |=> (udf_q && sample_q == 16'h0));

  p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_cmd |=> (fifo_level == '0));

  p_irq_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rx || irq_err) |-> (en_q && !idis_q));

  p_hold_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seq_hold |-> !conv_req);

  p_rx_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_q) |-> $past(push_acc));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .idis_q(idis_q), .irq_rx(irq_rx),
  .irq_err(irq_err), .rx_q(rx_q), .ovf_q(ovf_q), .udf_q(udf_q),
  .push_acc(push_acc), .push_drop(push_drop), .pop_miss(pop_miss),
  .flush_cmd(flush_cmd), .fifo_level(fifo_level), .conv_req(conv_req),
  .seq_hold(seq_hold), .sample_q(sample_q)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb_top;
  localparam int LAT = 4;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd4;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_rx, irq_err;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;
  bit run_cmp = 0;
  logic [31:0] setv = '0;

  always #2 clk = ~clk;

  adc_seq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_rx(irq_rx), .irq_err(irq_err)
  );

  // reference model state
  logic [15:0] fq[$];
  logic [4:0]  m_ch [64];
  int          m_dl [64];
  int m_wp, m_idx, m_left, m_cnt, m_thr;
  bit m_en, m_dis, m_rep, m_run, m_hold, m_rx, m_ovf, m_udf;
  logic [15:0] m_sample;

  function automatic logic [15:0] smp(input int ch);
    return 16'hA000 | 16'((31 - ch) << 5) | 16'(ch);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    fq.delete();
    m_wp = 0; m_idx = 0; m_left = 0; m_cnt = 0; m_thr = 0;
    m_en = 0; m_dis = 0; m_rep = 0; m_run = 0; m_hold = 0;
    m_rx = 0; m_ovf = 0; m_udf = 0; m_sample = '0;
  endtask

  task automatic model_step();
    bit cw, sw, tw, push;
    logic [15:0] pv;
    cw = wr_en && addr == 3'd0;
    sw = wr_en && addr == 3'd1;
    tw = wr_en && addr == 3'd2;
    push = 0; pv = '0;
    if (cw && wdata[5]) m_rx = 0;
    if (cw && wdata[6]) begin m_ovf = 0; m_udf = 0; end
    if (sw && wdata[14]) begin
      if (fq.size() > 0) m_sample = fq.pop_front();
      else begin m_sample = '0; m_udf = 1; end
    end
    if (!m_en) begin
      m_run = 0; m_hold = 0;
    end else if ((cw && wdata[3]) || (cw && wdata[4] && m_hold)) begin
      m_run = 1; m_hold = 0; m_idx = 0; m_left = m_dl[0] + 1 + LAT;
    end else if (cw && wdata[4]) begin
      m_run = 0;
    end else if (m_run) begin
      m_left--;
      if (m_left == 0) begin
        push = 1; pv = smp(m_ch[m_idx]);
        if (m_idx != m_cnt) begin
          m_idx++; m_left = m_dl[m_idx] + 1 + LAT;
        end else if (m_rep) begin
          m_idx = 0; m_left = m_dl[0] + 1 + LAT;
        end else begin
          m_run = 0; m_hold = 1;
        end
      end
    end
    if (cw && wdata[2]) begin m_idx = 0; m_wp = 0; end
    if (sw && wdata[15]) begin fq.delete(); push = 0; end
    if (push) begin
      if (fq.size() < DEPTH) begin
        fq.push_back(pv);
        if (fq.size() > m_thr) m_rx = 1;
      end else m_ovf = 1;
    end
    if (cw) begin m_en = wdata[0]; m_dis = wdata[1]; end
    if (sw) begin m_rep = wdata[13]; m_cnt = int'(wdata[21:16]); m_thr = int'(wdata[29:24]); end
    if (tw) begin
      m_ch[m_wp] = wdata[4:0];           m_dl[m_wp] = int'(wdata[15:5]);
      m_ch[(m_wp+1)%64] = wdata[20:16];  m_dl[(m_wp+1)%64] = int'(wdata[31:21]);
      m_wp = (m_wp + 2) % 64;
    end
  endtask

  function automatic logic [31:0] exp_status();
    return {19'b0, m_hold, m_run, m_udf, m_ovf, m_rx, 8'(fq.size())};
  endfunction

  // per-clock comparison against the model
  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step();
    #1;
    if (rst_n && run_cmp) begin
      check("R9 R12 irq_rx", 32'(irq_rx), 32'(m_rx && m_en && !m_dis));
      check("R8 R11 irq_err", 32'(irq_err), 32'((m_ovf || m_udf) && m_en && !m_dis));
      if (addr == 3'd4) check("R3 R5 status", rdata, exp_status());
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 3'd4; wdata = '0;
  endtask

  task automatic pop_read(input string tag, input logic [31:0] exp);
    wr(3'd1, setv | 32'h4000);
    addr = 3'd3;
    #1;
    check(tag, rdata, exp);
    addr = 3'd4;
  endtask

  task automatic status_is(input string tag, input logic [31:0] mask, input logic [31:0] exp);
    @(negedge clk);
    check(tag, rdata & mask, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run_cmp = 1;
    @(negedge clk);
    check("R1 status after reset", rdata, 32'h0);
    check("R1 irq_rx after reset", 32'(irq_rx), 32'h0);
    check("R1 irq_err after reset", 32'(irq_err), 32'h0);

    // single-shot, 3 entries, threshold 3
    wr(3'd0, 32'h1);
    setv = (32'd2 << 24) | (32'd2 << 16);
    wr(3'd1, setv);
    wr(3'd2, (32'd7 << 21) | (32'd30 << 16) | (32'd7 << 5) | 32'd31);
    wr(3'd0, 32'h5);                                  // R2 pointer reset
    wr(3'd2, (32'd0 << 21) | (32'd17 << 16) | (32'd2 << 5) | 32'd3);
    wr(3'd2, (32'd5 << 5) | 32'd9);
    wr(3'd0, 32'h9);
    repeat (6) @(negedge clk);
    check("R3 no sample before d+1+LAT", rdata & 32'hFF, 32'h0);
    @(negedge clk);
    check("R3 first sample at d+1+LAT", rdata & 32'hFF, 32'h1);
    repeat (25) @(negedge clk);
    status_is("R4 halted after last entry", 32'h1FFF, 32'h1103);
    check("R9 irq_rx at threshold", 32'(irq_rx), 32'h1);
    pop_read("R2 R6 first entry value", 32'(smp(3)));
    pop_read("R2 R6 second entry value", 32'(smp(17)));
    pop_read("R6 third entry value", 32'(smp(9)));
    status_is("R6 level after pops", 32'hFF, 32'h0);

    // underflow and error clear
    pop_read("R7 empty pop reads zero", 32'h0);
    status_is("R7 underflow flag", 32'h400, 32'h400);
    check("R7 irq_err on underflow", 32'(irq_err), 32'h1);
    wr(3'd0, 32'h41);
    status_is("R11 error flags cleared", 32'h600, 32'h0);
    check("R11 irq_err cleared", 32'(irq_err), 32'h0);

    // interrupt disable gating
    wr(3'd0, 32'h3);
    check("R12 irq_rx masked by disable", 32'(irq_rx), 32'h0);
    status_is("R12 flag kept while masked", 32'h100, 32'h100);
    wr(3'd0, 32'h1);
    check("R12 irq_rx back after unmask", 32'(irq_rx), 32'h1);
    wr(3'd0, 32'h21);
    status_is("R9 clear-data drops flag", 32'h100, 32'h0);

    // resume from halt restarts, then flush
    wr(3'd0, 32'h11);
    repeat (30) @(negedge clk);
    status_is("R4 resume reran table", 32'h10FF, 32'h1003);
    wr(3'd1, setv | 32'h8000);
    status_is("R10 flush empties", 32'hFF, 32'h0);
    wr(3'd0, 32'h21);

    // repetitive mode with overflow
    setv = (32'd7 << 24) | (32'd1 << 16) | (32'd1 << 13);
    wr(3'd1, setv);
    wr(3'd0, 32'h5);
    wr(3'd2, (32'd5 << 16) | 32'd20);
    wr(3'd0, 32'h9);
    repeat (200) @(negedge clk);
    status_is("R8 full and overflow", 32'hAFF, 32'hA20);
    check("R8 irq_err on overflow", 32'(irq_err), 32'h1);
    pop_read("R5 wrap value entry 0", 32'(smp(20)));
    pop_read("R5 wrap value entry 1", 32'(smp(5)));
    pop_read("R5 wrap value entry 0 again", 32'(smp(20)));
    wr(3'd0, 32'h11);
    status_is("R5 resume stops repetition", 32'h1800, 32'h0);
    wr(3'd1, setv | 32'h8000);
    wr(3'd0, 32'h61);
    status_is("R11 R10 cleared state", 32'h7FF, 32'h0);

    // start while disabled is ignored
    wr(3'd0, 32'h0);
    wr(3'd0, 32'h9);
    repeat (12) @(negedge clk);
    status_is("R12 start ignored while disabled", 32'h18FF, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule